// File: doc/BRIEF.md
# Prescaled I2C SCL Timing Generator

This block produces the serial clock timing for an I2C bus master. A shared prescaler turns the functional clock into a slower tick, nominally about 12 MHz. The high and low halves of each SCL period are then counted in those ticks. Two independent phase settings are used, one for the low half and one for the high half. Each setting has a fixed hardware offset of 7 ticks added to it. With suitable values the bus reaches both the 100 kHz and the 400 kHz rate.

The block drives only an open-drain pull-down request (`scl_drive_low`). It senses the real line level on `scl_in`, which must already be synchronised to `clk`. The high count does not begin until the line is seen high, and it freezes while a slave holds the line low. This is how clock stretching is honoured. Two single-cycle strobes tell the byte engine where to act on SDA. `launch_stb` falls near the middle of each low phase and marks where SDA may change. `sample_stb` falls near the middle of each high phase and marks where SDA is read.

Settings are expected to be stable while `enable` is high. The controller has four states:
- `ST_IDLE`: SCL released, counters cleared.
- `ST_LOW`: SCL pulled low.
- `ST_WAIT_HIGH`: SCL released, waiting for the line to rise.
- `ST_HIGH`: SCL released, high count running.

The transitions are:
- IDLE→LOW when `enable` is seen high.
- LOW→WAIT_HIGH on the last tick of the low count.
- WAIT_HIGH→HIGH when `scl_in` is high.
- HIGH→LOW on the last tick of the high count.
- Any state→IDLE when `enable` is low.

Top module: `scl_timing_gen`

## Requirements
- R1: While `enable` is low (and after reset), `scl_drive_low`, `launch_stb` and `sample_stb` are all 0.
- R2: A prescaler value P makes every tick last P+1 clocks, so both phase durations scale by P+1.
- R3: Each low phase (`scl_drive_low` high) lasts exactly (L+7)*(P+1) clocks, where L is `low_cnt`.
- R4: When `scl_in` follows the line without stretching, each released phase lasts (H+7)*(P+1)+1 clocks, where H is `high_cnt`. The extra clock is the one in which the rising line is observed.
- R5: If a slave keeps `scl_in` low for S clocks after release, the released phase grows by exactly S clocks. The high count never advances and never ends while `scl_in` is low.
- R6: Exactly one `launch_stb` occurs per low phase. It falls at clock ((L+7)>>1)*(P+1)+P, counting the first low clock as 0, and only while `scl_drive_low` is high.
- R7: Exactly one `sample_stb` occurs per high phase. It falls at clock 1+S+((H+7)>>1)*(P+1)+P, counting the first released clock as 0, and only while SCL is released and `scl_in` is high.
- R8: `scl_drive_low` goes high in the clock after `enable` is first seen high, so every run starts with a low phase.
- R9: Dropping `enable` in any phase releases SCL on the next clock. A later enable starts again with a full low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the SCL generator; low forces idle |
| psc_val | input | PSC_W (8) | Prescaler value P, tick = P+1 clocks |
| low_cnt | input | PH_W (8) | Low-phase setting L, phase = L+7 ticks |
| high_cnt | input | PH_W (8) | High-phase setting H, phase = H+7 ticks |
| scl_in | input | 1 | Synchronised sensed SCL level |
| scl_drive_low | output | 1 | Request to pull SCL low |
| launch_stb | output | 1 | One-clock strobe mid low phase (SDA change point) |
| sample_stb | output | 1 | One-clock strobe mid high phase (SDA sample point) |

## Verification
The checker watches a set of properties on every clock:
- Each strobe appears only in its own phase.
- A released line that is held low never turns back into a low phase.
- Enabling always starts with a low phase.
- Disabling releases SCL and silences both strobes one clock later.

The exact phase lengths, the exact strobe positions and the one-strobe-per-phase rule depend on P, L, H and the stretch length. Only the directed scenarios can show these. They measure whole periods with several prescaler and phase settings, with a stretching slave, and with a mid-phase disable.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_LOW       = 2'd1,
        ST_WAIT_HIGH = 2'd2,
        ST_HIGH      = 2'd3
    } scl_state_t;

    // Ticks added by hardware on top of each programmed phase value
    localparam int PHASE_OFFSET = 7;

endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [PSC_W-1:0] divisor,
    output logic             tick
);
    logic [PSC_W-1:0] div_cnt;

    assign tick = run && (div_cnt == divisor);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_cnt <= '0;
        else if (!run || restart || tick)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + 1'b1;
    end
endmodule

// File: rtl/scl_phase_counter.sv
module scl_phase_counter #(
    parameter int LEN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [LEN_W-1:0] phase_len,
    output logic             last,
    output logic             mid
);
    logic [LEN_W-1:0] tick_cnt;

    assign last = tick && (tick_cnt == phase_len - 1'b1);
    assign mid  = tick && (tick_cnt == (phase_len >> 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tick_cnt <= '0;
        else if (clear)
            tick_cnt <= '0;
        else if (tick)
            tick_cnt <= tick_cnt + 1'b1;
    end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_gen_pkg::*;
#(
    parameter int PSC_W = 8,
    parameter int PH_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PSC_W-1:0] psc_val,
    input  logic [PH_W-1:0]  low_cnt,
    input  logic [PH_W-1:0]  high_cnt,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             launch_stb,
    output logic             sample_stb
);
    localparam int LEN_W = PH_W + 1;
    localparam logic [LEN_W-1:0] OFFS = LEN_W'(PHASE_OFFSET);

    scl_state_t       state_q, state_d;
    logic             pre_tick, ph_tick, ph_last, ph_mid, ph_start, counting;
    logic [LEN_W-1:0] low_len, high_len, cur_len;

    assign low_len  = {1'b0, low_cnt} + OFFS;
    assign high_len = {1'b0, high_cnt} + OFFS;
    assign cur_len  = (state_q == ST_HIGH) ? high_len : low_len;
    assign counting = enable && (state_q == ST_LOW || state_q == ST_HIGH);
    // High count freezes while the line is held low by another device
    assign ph_tick  = pre_tick && (state_q != ST_HIGH || scl_in);
    assign ph_start = (state_d != state_q) && (state_d == ST_LOW || state_d == ST_HIGH);

    scl_prescaler #(.PSC_W(PSC_W)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (counting),
        .restart (ph_start),
        .divisor (psc_val),
        .tick    (pre_tick)
    );

    scl_phase_counter #(.LEN_W(LEN_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (ph_start || !counting),
        .tick      (ph_tick),
        .phase_len (cur_len),
        .last      (ph_last),
        .mid       (ph_mid)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (enable)  state_d = ST_LOW;
            ST_LOW:       if (ph_last) state_d = ST_WAIT_HIGH;
            ST_WAIT_HIGH: if (scl_in)  state_d = ST_HIGH;
            ST_HIGH:      if (ph_last) state_d = ST_LOW;
            default:                   state_d = ST_IDLE;
        endcase
        if (!enable)
            state_d = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Outputs
    always_comb begin
        scl_drive_low = (state_q == ST_LOW);
        launch_stb    = (state_q == ST_LOW)  && ph_mid;
        sample_stb    = (state_q == ST_HIGH) && ph_mid;
    end
endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic scl_in,
    input logic scl_drive_low,
    input logic launch_stb,
    input logic sample_stb
);
    // R1 and R9: a low enable leaves everything quiet one clock later
    p_disable_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!scl_drive_low && !launch_stb && !sample_stb));

    p_launch_in_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        launch_stb |-> (scl_drive_low && !sample_stb));

    p_sample_in_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (!scl_drive_low && scl_in));

    p_stretch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $past(enable) && $past(rst_n) && !scl_drive_low && !scl_in)
        |=> !scl_drive_low);

    p_enable_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && $rose(enable)) |=> scl_drive_low);
endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .scl_in        (scl_in),
    .scl_drive_low (scl_drive_low),
    .launch_stb    (launch_stb),
    .sample_stb    (sample_stb)
);

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] psc_val = '0, low_cnt = '0, high_cnt = '0;
    logic       stretch = 1'b0;
    logic       scl_in, scl_drive_low, launch_stb, sample_stb;
    int checks = 0, failures = 0;

    // Open-drain line: low if the master pulls or a slave stretches
    assign scl_in = !scl_drive_low && !stretch;

    always #5 clk = ~clk;

    scl_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .psc_val(psc_val),
        .low_cnt(low_cnt), .high_cnt(high_cnt), .scl_in(scl_in),
        .scl_drive_low(scl_drive_low), .launch_stb(launch_stb), .sample_stb(sample_stb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic test_reset();
        int bad = 0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (scl_drive_low || launch_stb || sample_stb) bad++;
        end
        chk(bad == 0, "R1 idle after reset", bad, 0);
    endtask

    // One full period; p, l, h settings and s stretch clocks
    task automatic run_case(input int p, input int l, input int h, input int s, input string tag);
        int low_exp  = (l + 7) * (p + 1);
        int rel_exp  = (h + 7) * (p + 1) + 1 + s;
        int lo_off_e = ((l + 7) >> 1) * (p + 1) + p;
        int sa_off_e = 1 + s + ((h + 7) >> 1) * (p + 1) + p;
        int i = 0, j = 0, n_l = 0, n_s = 0, lo_off = -1, sa_off = -1, wrong = 0;
        @(negedge clk);
        psc_val = 8'(p); low_cnt = 8'(l); high_cnt = 8'(h);
        stretch = (s > 0);
        enable = 1'b1;
        @(negedge clk);
        chk(scl_drive_low == 1'b1, {"R8 low after enable ", tag}, int'(scl_drive_low), 1);
        while (scl_drive_low) begin
            if (launch_stb) begin n_l++; lo_off = i; end
            if (sample_stb) wrong++;
            @(negedge clk);
            i++;
        end
        chk(i == low_exp, {"R3 R2 low length ", tag}, i, low_exp);
        chk(n_l == 1, {"R6 launch count ", tag}, n_l, 1);
        chk(lo_off == lo_off_e, {"R6 launch offset ", tag}, lo_off, lo_off_e);
        while (!scl_drive_low) begin
            if (j == s) stretch = 1'b0;
            if (sample_stb) begin n_s++; sa_off = j; end
            if (launch_stb) wrong++;
            @(negedge clk);
            j++;
        end
        chk(j == rel_exp, {(s > 0) ? "R5 stretched length " : "R4 R2 released length ", tag}, j, rel_exp);
        chk(n_s == 1, {"R7 sample count ", tag}, n_s, 1);
        chk(sa_off == sa_off_e, {"R7 sample offset ", tag}, sa_off, sa_off_e);
        chk(wrong == 0, {"R6 R7 strobe in wrong phase ", tag}, wrong, 0);
        enable = 1'b0;
        @(negedge clk);
        chk(scl_drive_low == 1'b0, {"R9 release on disable ", tag}, int'(scl_drive_low), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic test_disable_mid();
        int bad = 0;
        @(negedge clk);
        psc_val = 8'd3; low_cnt = 8'd20; high_cnt = 8'd4;
        enable = 1'b1;
        repeat (10) @(negedge clk);
        chk(scl_drive_low == 1'b1, "R3 still low mid phase", int'(scl_drive_low), 1);
        enable = 1'b0;
        @(negedge clk);
        chk(scl_drive_low == 1'b0, "R9 mid-low disable releases", int'(scl_drive_low), 0);
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (scl_drive_low || launch_stb || sample_stb) bad++;
        end
        chk(bad == 0, "R1 quiet while disabled", bad, 0);
    endtask

    initial begin : watchdog
        #2_000_000;
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        test_reset();
        run_case(0, 0, 0, 0, "p0");
        run_case(3, 5, 2, 0, "p3");
        run_case(1, 20, 33, 0, "p1");
        run_case(0, 0, 0, 10, "stretch10");
        run_case(2, 4, 1, 5, "stretch5p2");
        test_disable_mid();
        run_case(3, 5, 2, 0, "restart");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule